// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Vector Selector

This block sits at the point where a small processor core retires one instruction and is about to fetch the next. At that point it decides whether the core must enter an interrupt handler instead. If an interrupt is taken, the block supplies the 8-bit vector number that indexes the handler table. It also says whether the saved return offset is the next instruction or the current one. A core sequencer uses these outputs to run the entry sequence. The external bus acknowledge cycles and the entry sequence itself are not part of this block.

Requests come from several sources:

- internal events: a divider result that overflows its destination, and the single-step trap flag;
- decoded instructions: software interrupt with an operand, one-byte breakpoint, and interrupt-on-overflow;
- a non-maskable input, which is edge detected and latched so that a short pulse is not lost;
- a maskable external request, which is honoured only while the interrupt-enable flag is set and which supplies its own vector on a byte bus.

Exactly one source wins at a boundary. The decision is registered, so it appears one clock after the boundary strobe.

Top module: `irq_vector_select`

## Requirements
- R1: A divide overflow at a boundary yields vector 0 with `ret_cur_o`=1 (resume at the faulting instruction); every other taken interrupt has `ret_cur_o`=0.
- R2: With the trap flag set and no higher source, a boundary yields vector 1.
- R3: A rising edge on `nmi_i` is latched until taken and yields vector 2 regardless of the interrupt-enable flag. One edge yields exactly one take.
- R4: The external request yields the vector on `intr_vec_i`, sampled at the boundary, only while `if_flag_i`=1. With `if_flag_i`=0 it is ignored.
- R5: A breakpoint decode yields vector 3.
- R6: Interrupt-on-overflow yields vector 4 when `of_flag_i`=1. When `of_flag_i`=0 it raises `nop_o` for one cycle and takes nothing itself, so lower sources are still considered.
- R7: A software interrupt decode yields the 8-bit operand on `swi_num_i` as the vector.
- R8: Decisions are made only on cycles with `boundary_i`=1. The results appear one cycle later, and `take_o` is a one-cycle strobe. When `take_o`=0, `vec_o`=0 and `ret_cur_o`=0.
- R9: Priority, highest first: divide overflow, then instruction-raised interrupts (software, breakpoint, overflow), then NMI, then the external request, then single step.
- R10: An NMI that loses to a higher source stays pending and is taken at the next boundary.
- R11: After reset, `take_o`, `vec_o`, `ret_cur_o` and `nop_o` are 0 and no NMI is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Current instruction completes this cycle |
| div_ovf_i | input | 1 | Divider result overflowed |
| swi_i | input | 1 | Software interrupt instruction decoded |
| swi_num_i | input | 8 | Operand of the software interrupt |
| brk_i | input | 1 | One-byte breakpoint decoded |
| into_i | input | 1 | Interrupt-on-overflow decoded |
| of_flag_i | input | 1 | Overflow flag |
| tf_flag_i | input | 1 | Trap (single-step) flag |
| if_flag_i | input | 1 | Interrupt-enable flag |
| nmi_i | input | 1 | Non-maskable request, asynchronous |
| intr_i | input | 1 | Maskable external request, level |
| intr_vec_i | input | 8 | Vector supplied with the external request |
| take_o | output | 1 | Interrupt taken strobe |
| vec_o | output | 8 | Vector number of the taken interrupt |
| ret_cur_o | output | 1 | 1: return to current instruction, 0: to next |
| nop_o | output | 1 | Overflow-check instruction acted as no-operation |

## Verification
The checker watches the following on every cycle: take strobes never appear without a preceding boundary, outputs stay idle between decisions, a divide fault always wins with the current-instruction return, a masked external request alone never produces a take, and a pending NMI without higher competition is taken. Other behaviours can only be shown by the bench's scenarios, because each needs a sequence of several boundaries. These are the operand vector values, the sampling of the external vector, an NMI surviving a lost arbitration, one take per NMI edge, and the full priority ladder between pairs of sources.

// File: rtl/ivsel_pkg.sv
package ivsel_pkg;
    localparam int IVS_VEC_W   = 8;
    localparam int IVS_V_DIV   = 0;
    localparam int IVS_V_STEP  = 1;
    localparam int IVS_V_NMI   = 2;
    localparam int IVS_V_BRK   = 3;
    localparam int IVS_V_OVF   = 4;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_DIV,
        SRC_INSN,
        SRC_NMI,
        SRC_EXT,
        SRC_STEP
    } ivs_src_e;
endpackage

// File: rtl/ivsel_nmi_edge.sv
module ivsel_nmi_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb sync_d = nmi_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[SYNC_STAGES-2:0], nmi_i};
        end
    endgenerate

    always_comb prev_d = sync_q[SYNC_STAGES-1];
    always_comb rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/ivsel_arbiter.sv
module ivsel_arbiter
    import ivsel_pkg::*;
#(
    parameter int VEC_W = IVS_VEC_W
) (
    input  logic             div_ovf_i,
    input  logic             swi_i,
    input  logic [VEC_W-1:0] swi_num_i,
    input  logic             brk_i,
    input  logic             into_i,
    input  logic             of_flag_i,
    input  logic             nmi_pend_i,
    input  logic             intr_i,
    input  logic             if_flag_i,
    input  logic [VEC_W-1:0] intr_vec_i,
    input  logic             tf_flag_i,
    output ivs_src_e         src_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             nop_o
);
    always_comb begin
        src_o = SRC_NONE;
        vec_o = '0;
        nop_o = into_i & ~of_flag_i & ~div_ovf_i;
        if (div_ovf_i) begin
            src_o = SRC_DIV;
            vec_o = VEC_W'(IVS_V_DIV);
        end else if (swi_i) begin
            src_o = SRC_INSN;
            vec_o = swi_num_i;
        end else if (brk_i) begin
            src_o = SRC_INSN;
            vec_o = VEC_W'(IVS_V_BRK);
        end else if (into_i && of_flag_i) begin
            src_o = SRC_INSN;
            vec_o = VEC_W'(IVS_V_OVF);
        end else if (nmi_pend_i) begin
            src_o = SRC_NMI;
            vec_o = VEC_W'(IVS_V_NMI);
        end else if (intr_i && if_flag_i) begin
            src_o = SRC_EXT;
            vec_o = intr_vec_i;
        end else if (tf_flag_i) begin
            src_o = SRC_STEP;
            vec_o = VEC_W'(IVS_V_STEP);
        end
    end
endmodule

// File: rtl/irq_vector_select.sv
module irq_vector_select
    import ivsel_pkg::*;
#(
    parameter int VEC_W       = IVS_VEC_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             div_ovf_i,
    input  logic             swi_i,
    input  logic [VEC_W-1:0] swi_num_i,
    input  logic             brk_i,
    input  logic             into_i,
    input  logic             of_flag_i,
    input  logic             tf_flag_i,
    input  logic             if_flag_i,
    input  logic             nmi_i,
    input  logic             intr_i,
    input  logic [VEC_W-1:0] intr_vec_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ret_cur_o,
    output logic             nop_o
);
    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             ret_cur;
        logic             nop;
        logic             nmi_pend;
    } state_t;

    state_t           st_d, st_q;
    logic             nmi_rise;
    logic             nmi_pend_eff;
    ivs_src_e         sel_src;
    logic [VEC_W-1:0] sel_vec;
    logic             sel_nop;

    ivsel_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .rise_o (nmi_rise)
    );

    always_comb nmi_pend_eff = st_q.nmi_pend | nmi_rise;

    ivsel_arbiter #(.VEC_W(VEC_W)) u_arb (
        .div_ovf_i  (div_ovf_i),
        .swi_i      (swi_i),
        .swi_num_i  (swi_num_i),
        .brk_i      (brk_i),
        .into_i     (into_i),
        .of_flag_i  (of_flag_i),
        .nmi_pend_i (nmi_pend_eff),
        .intr_i     (intr_i),
        .if_flag_i  (if_flag_i),
        .intr_vec_i (intr_vec_i),
        .tf_flag_i  (tf_flag_i),
        .src_o      (sel_src),
        .vec_o      (sel_vec),
        .nop_o      (sel_nop)
    );

    always_comb begin
        st_d          = '0;
        st_d.nmi_pend = nmi_pend_eff;
        if (boundary_i) begin
            st_d.take    = (sel_src != SRC_NONE);
            st_d.vec     = sel_vec;
            st_d.ret_cur = (sel_src == SRC_DIV);
            st_d.nop     = sel_nop;
            if (sel_src == SRC_NMI) st_d.nmi_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o    = st_q.take;
    assign vec_o     = st_q.vec;
    assign ret_cur_o = st_q.ret_cur;
    assign nop_o     = st_q.nop;
endmodule

// File: rtl/irq_vector_select_chk.sv
module irq_vector_select_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boundary_i,
    input logic             div_ovf_i,
    input logic             swi_i,
    input logic             brk_i,
    input logic             into_i,
    input logic             of_flag_i,
    input logic             tf_flag_i,
    input logic             if_flag_i,
    input logic             intr_i,
    input logic             nmi_pend_eff,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             ret_cur_o,
    input logic             nop_o
);
    p_take_after_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));

    p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vec_o == '0 && !ret_cur_o));

    p_div_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && div_ovf_i) |=> (take_o && vec_o == '0 && ret_cur_o));

    p_ret_cur_only_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cur_o |-> $past(div_ovf_i));

    p_masked_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && intr_i && !if_flag_i && !tf_flag_i && !div_ovf_i && !swi_i
         && !brk_i && !(into_i && of_flag_i) && !nmi_pend_eff) |=> !take_o);

    p_nmi_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && nmi_pend_eff && !div_ovf_i && !swi_i && !brk_i
         && !(into_i && of_flag_i)) |=> (take_o && vec_o == VEC_W'(2)));

    p_into_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && into_i && !of_flag_i && !div_ovf_i) |=> (nop_o && vec_o != VEC_W'(4)));
endmodule

bind irq_vector_select irq_vector_select_chk #(.VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .div_ovf_i    (div_ovf_i),
    .swi_i        (swi_i),
    .brk_i        (brk_i),
    .into_i       (into_i),
    .of_flag_i    (of_flag_i),
    .tf_flag_i    (tf_flag_i),
    .if_flag_i    (if_flag_i),
    .intr_i       (intr_i),
    .nmi_pend_eff (nmi_pend_eff),
    .take_o       (take_o),
    .vec_o        (vec_o),
    .ret_cur_o    (ret_cur_o),
    .nop_o        (nop_o)
);

// File: tb/test_irq_vector_select.sv
`timescale 1ns/1ps
module test_irq_vector_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boundary_i = 1'b0, div_ovf_i = 1'b0, swi_i = 1'b0, brk_i = 1'b0;
    logic       into_i = 1'b0, of_flag_i = 1'b0, tf_flag_i = 1'b0, if_flag_i = 1'b0;
    logic       nmi_i = 1'b0, intr_i = 1'b0;
    logic [7:0] swi_num_i = 8'h00, intr_vec_i = 8'h00;
    logic       take_o, ret_cur_o, nop_o;
    logic [7:0] vec_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit       take;
        bit [7:0] vec;
        bit       rc;
        bit       nop;
        string    tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    irq_vector_select i_irq_vector_select (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .div_ovf_i(div_ovf_i),
        .swi_i(swi_i), .swi_num_i(swi_num_i), .brk_i(brk_i), .into_i(into_i),
        .of_flag_i(of_flag_i), .tf_flag_i(tf_flag_i), .if_flag_i(if_flag_i),
        .nmi_i(nmi_i), .intr_i(intr_i), .intr_vec_i(intr_vec_i),
        .take_o(take_o), .vec_o(vec_o), .ret_cur_o(ret_cur_o), .nop_o(nop_o)
    );

    task automatic fire(input bit t, input bit [7:0] v, input bit rc, input bit nop, input string tag);
        exp_t e;
        e.take = t; e.vec = v; e.rc = rc; e.nop = nop; e.tag = tag;
        sb.push_back(e);
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        div_ovf_i = 1'b0; swi_i = 1'b0; brk_i = 1'b0; into_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic nmi_pulse();
        nmi_i = 1'b1;
        repeat (3) @(negedge clk);
        nmi_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor: compares results one cycle after each boundary
    initial begin
        forever begin
            bit b;
            @(posedge clk);
            b = boundary_i;
            #1;
            if (rst_n) begin
                checks++;
                if (b) begin
                    if (sb.size() == 0) begin
                        fails++;
                        $display("FAIL R8 unexpected boundary result, actual take=%0d expected none", take_o);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (take_o !== e.take || vec_o !== e.vec || ret_cur_o !== e.rc || nop_o !== e.nop) begin
                            fails++;
                            $display("FAIL %s actual take=%0d vec=%0h rc=%0d nop=%0d expected take=%0d vec=%0h rc=%0d nop=%0d",
                                     e.tag, take_o, vec_o, ret_cur_o, nop_o, e.take, e.vec, e.rc, e.nop);
                        end
                    end
                end else if (take_o !== 1'b0 || vec_o !== 8'h00 || nop_o !== 1'b0) begin
                    fails++;
                    $display("FAIL R8 output without boundary, actual take=%0d vec=%0h nop=%0d expected 0 0 0",
                             take_o, vec_o, nop_o);
                end
            end
        end
    end

    initial begin
        bit timeout = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R11 reset state
                checks++;
                if (take_o !== 1'b0 || vec_o !== 8'h00 || ret_cur_o !== 1'b0 || nop_o !== 1'b0) begin
                    fails++;
                    $display("FAIL R11 reset state actual %0d %0h %0d %0d expected 0 0 0 0",
                             take_o, vec_o, ret_cur_o, nop_o);
                end
                fire(0, 8'h00, 0, 0, "R11 no pending after reset");

                swi_i = 1; swi_num_i = 8'h21;       fire(1, 8'h21, 0, 0, "R7 soft int 21");
                swi_i = 1; swi_num_i = 8'hFF;       fire(1, 8'hFF, 0, 0, "R7 soft int FF");
                brk_i = 1;                          fire(1, 8'h03, 0, 0, "R5 breakpoint");
                into_i = 1; of_flag_i = 1;          fire(1, 8'h04, 0, 0, "R6 overflow set");
                into_i = 1; of_flag_i = 0;          fire(0, 8'h00, 0, 1, "R6 overflow clear nop");
                div_ovf_i = 1;                      fire(1, 8'h00, 1, 0, "R1 divide fault");
                tf_flag_i = 1;                      fire(1, 8'h01, 0, 0, "R2 single step");
                into_i = 1;                         fire(1, 8'h01, 0, 1, "R6 nop with step below");
                div_ovf_i = 1;                      fire(1, 8'h00, 1, 0, "R9 divide over step");
                tf_flag_i = 0;

                intr_i = 1; if_flag_i = 0; intr_vec_i = 8'h48;
                // R8: pending requests without boundary produce nothing (monitor checks)
                repeat (4) @(negedge clk);
                fire(0, 8'h00, 0, 0, "R4 masked request");
                if_flag_i = 1;                      fire(1, 8'h48, 0, 0, "R4 enabled request");
                intr_vec_i = 8'h9C;                 fire(1, 8'h9C, 0, 0, "R4 vector sampled");
                tf_flag_i = 1;                      fire(1, 8'h9C, 0, 0, "R9 request over step");
                tf_flag_i = 0; intr_i = 0;

                if_flag_i = 0; nmi_pulse();
                repeat (10) @(negedge clk);
                fire(1, 8'h02, 0, 0, "R3 nmi unmaskable");
                fire(0, 8'h00, 0, 0, "R3 nmi cleared once taken");

                nmi_pulse();
                swi_i = 1; swi_num_i = 8'h10;       fire(1, 8'h10, 0, 0, "R10 soft int beats nmi");
                fire(1, 8'h02, 0, 0, "R10 nmi kept pending");

                nmi_pulse();
                intr_i = 1; if_flag_i = 1; intr_vec_i = 8'h77;
                fire(1, 8'h02, 0, 0, "R9 nmi over request");
                fire(1, 8'h77, 0, 0, "R9 request after nmi");
                intr_i = 0;
                repeat (3) @(negedge clk);
            end
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual hung expected completion");
        end
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R8 results missing actual %0d left expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule